// File: doc/BRIEF.md
# Clock Postscaler and Doze Controller

This block holds a 16-bit clock-divider control register and the enable logic it steers. Running entirely on the oscillator clock, it produces a peripheral clock-enable that pulses once every D oscillator cycles, where D is picked by a postscaler code. From those peripheral pulses it derives a CPU clock-enable that can be thinned out by a doze ratio, so the processor runs slower than the peripherals while the peripherals keep their rate. Both enables are single-cycle pulses on the oscillator domain; downstream logic gates its registers with them instead of using derived clocks.

An interrupt-recovery flag lets an arriving interrupt drop doze mode in hardware: with the flag armed, an interrupt-pending pulse clears the doze enable and the CPU returns to full peripheral rate on the very next peripheral pulse. A source-select input tells the block which oscillator currently drives its clock; any change of it restarts the postscaler count so the first period after a switch is a full one. Software writes the register whole and reads back its live contents.

Top module: `clkdiv_doze_top`

## Requirements
- R1: `rd_data` always shows the live register: bit 15 recovery flag, bits 14:12 doze code, bit 11 doze enable, bits 10:8 postscaler code, bits 7:0 read as zero; a write with `wr_en` high loads all fields from `wr_data` on that clock edge.
- R2: After reset the register reads 16'h3100 (recovery 0, doze code 3'b011, doze enable 0, postscaler code 3'b001), and the first peripheral pulse appears in the first cycle after reset is released.
- R3: Postscaler codes 0 to 6 give one `per_ce` pulse every 1, 2, 4, 8, 16, 32 and 64 oscillator cycles; code 0 holds `per_ce` high every cycle.
- R4: Postscaler code 7 gives one `per_ce` pulse every 256 oscillator cycles (there is no divide-by-128 step).
- R5: While doze enable is 0, `cpu_ce` equals `per_ce` in every cycle whatever the doze code holds.
- R6: While doze enable is 1 with doze code k (0 to 7), `cpu_ce` is high only in cycles where `per_ce` is high, once every 2^k peripheral pulses, starting with the first peripheral pulse after doze is enabled.
- R7: An `irq_pend` pulse while the recovery flag is 1 clears doze enable on that clock edge; with the recovery flag 0 an `irq_pend` pulse leaves doze enable unchanged.
- R8: When a write setting doze enable coincides with an `irq_pend` pulse and the stored recovery flag is 1, doze enable ends up 0.
- R9: A new postscaler or doze code takes effect only when the running count next reaches its terminal value; no period already under way is shortened.
- R10: A change of `src_sel` restarts the postscaler: the next `per_ce` comes D cycles after the clock edge that sees the change, with D from the current code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock, the only clock of the block |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write value |
| rd_data | output | 16 | Live register value |
| src_sel | input | 1 | Current oscillator source; a change restarts the postscaler |
| irq_pend | input | 1 | One-cycle interrupt-pending pulse |
| per_ce | output | 1 | Peripheral clock-enable pulse |
| cpu_ce | output | 1 | CPU clock-enable pulse |

## Verification
A wrong postscaler count shows up at `per_ce` within one divide period, at most 256 cycles, as a pulse that is early, late or missing. A doze counter out of step shows as a `cpu_ce` pulse in the wrong peripheral slot within 2^k peripheral pulses, or at once as a `cpu_ce` without `per_ce`. A doze enable that is wrongly kept or cleared around an interrupt is visible on `rd_data` bit 11 in the cycle after the pulse and on `cpu_ce` at the next peripheral pulse.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  localparam int REG_W     = 16;
  localparam int CODE_W    = 3;
  localparam int PS_CNT_W  = 8;   // holds divide-by-256 minus one
  localparam int DZ_CNT_W  = 7;   // holds ratio 128 minus one

  // Field positions that software decodes.
  localparam int REC_POS   = 15;
  localparam int DZ_LSB    = 12;
  localparam int DZEN_POS  = 11;
  localparam int PS_LSB    = 8;

  typedef struct packed {
    logic              recover;
    logic [CODE_W-1:0] doze_code;
    logic              doze_en;
    logic [CODE_W-1:0] post_code;
  } ctl_t;

  localparam ctl_t CTL_RESET = '{recover: 1'b0, doze_code: 3'b011,
                                 doze_en: 1'b0, post_code: 3'b001};

  // Postscaler reload: divisor minus one, top code jumps to 256.
  function automatic logic [PS_CNT_W-1:0] post_reload(input logic [CODE_W-1:0] code);
    logic [PS_CNT_W:0] span;
    logic [3:0]        sh;
    sh   = {1'b0, code} + {3'b000, (code == 3'b111)};
    span = (PS_CNT_W+1)'(1) << sh;
    return PS_CNT_W'(span - (PS_CNT_W+1)'(1));
  endfunction

  // Doze reload: ratio minus one.
  function automatic logic [DZ_CNT_W-1:0] doze_reload(input logic [CODE_W-1:0] code);
    logic [DZ_CNT_W:0] span;
    span = (DZ_CNT_W+1)'(1) << code;
    return DZ_CNT_W'(span - (DZ_CNT_W+1)'(1));
  endfunction

endpackage

// File: rtl/clkdiv_rst_sync.sv
module clkdiv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/clkdiv_ctl_reg.sv
module clkdiv_ctl_reg
  import clkdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             irq_pend,
  output ctl_t             ctl,
  output logic [REG_W-1:0] rd_data
);
  ctl_t ctl_q, ctl_d;
  logic [PS_LSB-1:0] unused_low;

  assign unused_low = wr_data[PS_LSB-1:0];

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en) begin
      ctl_d.recover   = wr_data[REC_POS];
      ctl_d.doze_code = wr_data[DZ_LSB +: CODE_W];
      ctl_d.doze_en   = wr_data[DZEN_POS];
      ctl_d.post_code = wr_data[PS_LSB +: CODE_W];
    end
    // Hardware recovery overrides a simultaneous software set.
    if (irq_pend && ctl_q.recover) ctl_d.doze_en = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= CTL_RESET;
    else        ctl_q <= ctl_d;
  end

  always_comb begin
    rd_data                     = '0;
    rd_data[REC_POS]            = ctl_q.recover;
    rd_data[DZ_LSB +: CODE_W]   = ctl_q.doze_code;
    rd_data[DZEN_POS]           = ctl_q.doze_en;
    rd_data[PS_LSB +: CODE_W]   = ctl_q.post_code;
  end

  assign ctl = ctl_q;

  AST_RECOVER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend && ctl_q.recover) |=> !ctl_q.doze_en); // R7

  AST_KEEP_DOZE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend && !ctl_q.recover && !wr_en) |=> $stable(ctl_q.doze_en)); // R7

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[DZEN_POS] && irq_pend && ctl_q.recover) |=> (rd_data[DZEN_POS] == 1'b0)); // R8

  AST_LOW_BYTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[PS_LSB-1:0] == '0); // R1
endmodule

// File: rtl/clkdiv_postscaler.sv
module clkdiv_postscaler
  import clkdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] post_code,
  input  logic              src_sel,
  output logic              per_ce
);
  logic [PS_CNT_W-1:0] cnt_q, cnt_d;
  logic                src_q;
  logic                restart;
  logic                term;

  assign term    = (cnt_q == '0);
  assign restart = (src_sel != src_q);

  always_comb begin
    cnt_d = cnt_q;
    if (restart || term) cnt_d = post_reload(post_code);
    else                 cnt_d = cnt_q - PS_CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      src_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      src_q <= src_sel;
    end
  end

  assign per_ce = term;

  AST_RESTART_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !per_ce || (post_code == '0) || $past(post_code == '0)); // R10
endmodule

// File: rtl/clkdiv_doze.sv
module clkdiv_doze
  import clkdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              per_ce,
  input  logic              doze_en,
  input  logic [CODE_W-1:0] doze_code,
  output logic              cpu_ce
);
  logic [DZ_CNT_W-1:0] dcnt_q, dcnt_d;
  logic                slot;

  assign slot = (dcnt_q == '0);

  always_comb begin
    dcnt_d = dcnt_q;
    if (!doze_en)          dcnt_d = '0;
    else if (per_ce) begin
      if (slot) dcnt_d = doze_reload(doze_code);
      else      dcnt_d = dcnt_q - DZ_CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dcnt_q <= '0;
    else        dcnt_q <= dcnt_d;
  end

  assign cpu_ce = per_ce && (!doze_en || slot);
endmodule

// File: rtl/clkdiv_doze_top.sv
module clkdiv_doze_top
  import clkdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             src_sel,
  input  logic             irq_pend,
  output logic             per_ce,
  output logic             cpu_ce
);
  logic rst_n_int;
  ctl_t ctl;

  clkdiv_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_int)
  );

  clkdiv_ctl_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .irq_pend (irq_pend),
    .ctl      (ctl),
    .rd_data  (rd_data)
  );

  clkdiv_postscaler u_ps (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .post_code (ctl.post_code),
    .src_sel   (src_sel),
    .per_ce    (per_ce)
  );

  clkdiv_doze u_dz (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .per_ce    (per_ce),
    .doze_en   (ctl.doze_en),
    .doze_code (ctl.doze_code),
    .cpu_ce    (cpu_ce)
  );

  AST_CPU_WITHIN_PER: assert property (@(posedge clk) disable iff (!rst_n_int)
    cpu_ce |-> per_ce); // R6

  AST_DOZE_OFF_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n_int)
    !rd_data[DZEN_POS] |-> (cpu_ce == per_ce)); // R5
endmodule

// File: tb/tb_clkdiv_doze_top.sv
module tb_clkdiv_doze_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        src_sel = 1'b0;
  logic        irq_pend = 1'b0;
  logic        per_ce, cpu_ce;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // Bench model state
  logic       m_rec, m_en;
  logic [2:0] m_dz, m_ps;
  int         m_pc, m_dc;
  logic       m_src;

  always #2 clk = ~clk;   // 250 MHz

  clkdiv_doze_top dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .src_sel(src_sel), .irq_pend(irq_pend),
    .per_ce(per_ce), .cpu_ce(cpu_ce)
  );

  function automatic int divisor(input logic [2:0] c);
    return (c == 3'd7) ? 256 : (1 << c);
  endfunction

  function automatic logic [15:0] exp_rd();
    return {m_rec, m_dz, m_en, m_ps, 8'h00};
  endfunction

  function automatic logic exp_per();
    return (m_pc == 0);
  endfunction

  function automatic logic exp_cpu();
    return m_en ? (exp_per() && m_dc == 0) : exp_per();
  endfunction

  task automatic model_reset();
    m_rec = 1'b0; m_dz = 3'b011; m_en = 1'b0; m_ps = 3'b001;
    m_pc = 0; m_dc = 0; m_src = 1'b0;
  endtask

  task automatic compare(input string tag);
    checks++;
    if (rd_data !== exp_rd() || per_ce !== exp_per() || cpu_ce !== exp_cpu()) begin
      errors++;
      $display("FAIL %s cyc=%0d rd=%h/%h per=%b/%b cpu=%b/%b", tag, cycles,
               rd_data, exp_rd(), per_ce, exp_per(), cpu_ce, exp_cpu());
    end
  endtask

  // One cycle: check outputs, apply inputs, advance model.
  task automatic step(input logic w, input logic [15:0] d, input logic irq,
                      input logic src, input string tag);
    int n_pc, n_dc;
    logic n_en;
    @(negedge clk);
    compare(tag);
    wr_en = w; wr_data = d; irq_pend = irq; src_sel = src;
    if (src != m_src || m_pc == 0) n_pc = divisor(m_ps) - 1;
    else                           n_pc = m_pc - 1;
    if (!m_en)           n_dc = 0;
    else if (m_pc == 0)  n_dc = (m_dc == 0) ? (1 << m_dz) - 1 : m_dc - 1;
    else                 n_dc = m_dc;
    n_en = w ? d[11] : m_en;
    if (irq && m_rec) n_en = 1'b0;
    @(posedge clk);
    if (w) begin m_rec = d[15]; m_dz = d[14:12]; m_ps = d[10:8]; end
    m_en = n_en; m_pc = n_pc; m_dc = n_dc; m_src = src;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 16'h0, 1'b0, src_sel, tag);
  endtask

  task automatic wr(input logic [15:0] d, input string tag);
    step(1'b1, d, 1'b0, src_sel, tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(posedge clk);
    model_reset();
    // R2: reset value and first pulse
    idle(6, "R2");

    // R3 / R4: every postscaler code
    for (int c = 0; c < 8; c++) begin
      wr(16'h3000 | (16'(c) << 8), (c == 7) ? "R4" : "R3");
      idle(divisor(3'(c)) * 3 + 4, (c == 7) ? "R4" : "R3");
    end

    // R5: doze code set but disabled
    wr(16'h7200, "R5");
    idle(40, "R5");

    // R6: every doze ratio with post code 0, then with post code 2
    for (int r = 0; r < 8; r++) begin
      wr((16'(r) << 12) | 16'h0800, "R6");
      idle(300, "R6");
    end
    wr(16'h2A00, "R6");
    idle(120, "R6");

    // R7: recovery armed, then disarmed
    wr(16'hB800, "R7");
    idle(20, "R7");
    step(1'b0, 16'h0, 1'b1, src_sel, "R7");
    idle(20, "R7");
    wr(16'h3800, "R7");
    idle(10, "R7");
    step(1'b0, 16'h0, 1'b1, src_sel, "R7");
    idle(20, "R7");

    // R8: write setting doze coincides with recovery interrupt
    wr(16'h8000, "R8");
    step(1'b1, 16'hB800, 1'b1, src_sel, "R8");
    idle(10, "R8");

    // R9: code changes mid-period
    wr(16'h0700, "R9");
    idle(60, "R9");
    wr(16'h0000, "R9");
    idle(230, "R9");
    wr(16'h6900, "R9");
    idle(50, "R9");
    wr(16'h1900, "R9");
    idle(200, "R9");

    // R10: source change restarts the count
    wr(16'h0400, "R10");
    idle(7, "R10");
    step(1'b0, 16'h0, 1'b0, ~src_sel, "R10");
    idle(40, "R10");
    step(1'b0, 16'h0, 1'b0, ~src_sel, "R10");
    idle(40, "R10");

    // R1: random mix of writes, interrupts and source changes
    for (int i = 0; i < 4000; i++) begin
      logic w, q, s;
      w = ($urandom % 40) == 0;
      q = ($urandom % 30) == 0;
      s = (($urandom % 300) == 0) ? ~src_sel : src_sel;
      step(w, 16'($urandom), q, s, "R1");
    end
    idle(4, "R1");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule